// File: doc/BRIEF.md
# Keypad Press Arbiter for an IR Command Transmitter

This block sits between a decoded key matrix and an infrared frame encoder. Each cycle it sees a vector of key-down flags, one per key. It decides whether a press is clean enough to transmit. It then hands the encoder an 8-bit command code with a one-cycle start pulse, and keeps a held level up while the chosen key stays down, so that the encoder can schedule repeat frames. Its timers count a one-millisecond tick input.

A clean press is a single key that stays alone for an arming window before anything is sent. Presses that overlap inside that window suppress transmission. Once a key has started a frame it keeps priority over keys pressed later. There is one exception. Key index 20 held alone, followed by key index 21, 22 or 23, can form a combined command when the second key arrives late enough. If the second key arrives too early, the transmission is cancelled with a stop pulse. A repeat-mode input disables the combined command altogether.

Top module: `keypad_arbiter`

## Requirements
- R1: After reset, `frame_go`, `frame_stop` and `key_held` are low and `data_code` is 0.
- R2: A single key pressed alone and kept alone gives exactly one `frame_go` pulse, on the `WAIT_MS`-th tick (default 36) counted after the press.
- R3: The code for key index k is bits[4:0] = k mod 32, bit5 = 0, bit6 = 1 when k < 32 and 0 otherwise, and bit7 = the inverse of `sel_strap`.
- R4: If two or more keys are down together before the arming window ends, no `frame_go` is produced.
- R5: A key released before its arming window ends produces no `frame_go`.
- R6: `key_held` rises with the start pulse and stays high while the chosen key is down. It is low on the cycle after all keys are released, or after the chosen key is released.
- R7: While a frame is under way, a later key that does not form the combination changes nothing. There is no new `frame_go`, no `frame_stop`, `key_held` stays high and `data_code` is unchanged.
- R8: With key index 20 transmitting and `rpt_mode` low, adding key index 21, 22 or 23 at `COMBO_MS` ticks (default 126) or later after the first press gives a second `frame_go`. Its code has bits[4:0] = second key index mod 32, bit5 = 1, bit6 = 0 and bit7 = the inverse of `sel_strap`.
- R9: The same combination that arrives after the window but before `COMBO_MS` ticks gives one `frame_stop` pulse, drops `key_held`, and produces no `frame_go`.
- R10: When `rpt_mode` is high, the combination is treated as in R7, and bit5 of any code is 0.
- R11: After a blocked or cancelled press, no `frame_go` is produced until every key has been released, even if a single key remains down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| keys | input | NKEYS | Key-down flags, bit k for key index k |
| sel_strap | input | 1 | Strap level; high clears code bit 7 |
| rpt_mode | input | 1 | Continuous repeat mode; disables the combined command |
| frame_go | output | 1 | One-cycle pulse: start a full frame with `data_code` |
| frame_stop | output | 1 | One-cycle pulse: cancel the current transmission |
| key_held | output | 1 | High while the transmitting key or key pair is held |
| data_code | output | 8 | Command code for the encoder |

## Verification
A wrong state shows at the ports within one cycle of the next event that should change it. A missed release keeps `key_held` high past the release cycle. A stale block state swallows the start pulse of the next clean press. A timer that is off by one moves `frame_go` away from tick 36. The same error turns the 126-tick combination boundary into a stop pulse. The bench therefore timestamps every start pulse in ticks since the press. It places second presses at exact tick offsets on both sides of each boundary.

// File: rtl/keypad_arbiter.sv
module keypad_arbiter #(
  parameter int NKEYS     = 64,
  parameter int WAIT_MS   = 36,
  parameter int COMBO_MS  = 126,
  parameter int COMBO_KEY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic [NKEYS-1:0] keys,
  input  logic             sel_strap,
  input  logic             rpt_mode,
  output logic             frame_go,
  output logic             frame_stop,
  output logic             key_held,
  output logic [7:0]       data_code
);
  localparam int IDXW = $clog2(NKEYS);
  localparam int TW   = $clog2(COMBO_MS + 1);
  localparam logic [IDXW-1:0] KEY_A   = IDXW'(COMBO_KEY);
  localparam logic [IDXW-1:0] PAIR_LO = IDXW'(COMBO_KEY + 1);
  localparam logic [IDXW-1:0] PAIR_HI = IDXW'(COMBO_KEY + 3);
  localparam logic [TW-1:0]   T_ARM   = TW'(WAIT_MS - 1);
  localparam logic [TW-1:0]   T_PAIR  = TW'(COMBO_MS);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SEND, S_PAIR, S_BLOCK} st_t;

  st_t             state;
  logic [IDXW-1:0] chosen, second;
  logic [TW-1:0]   timer;

  function automatic logic [IDXW-1:0] lowest(input logic [NKEYS-1:0] v);
    logic [IDXW-1:0] r = '0;
    for (int i = NKEYS - 1; i >= 0; i--)
      if (v[i]) r = IDXW'(i);
    return r;
  endfunction

  function automatic logic [7:0] make_code(input logic [IDXW-1:0] idx,
                                           input logic combo, input logic strap);
    return {~strap, combo ? 1'b0 : ~idx[IDXW-1], combo, idx[4:0]};
  endfunction

  logic             any_key, lone_key;
  logic [NKEYS-1:0] chosen_mask, others, pair_mask;
  logic [IDXW-1:0]  oth_idx;
  logic             pair_cand;

  assign any_key     = |keys;
  assign lone_key    = $onehot(keys);
  assign chosen_mask = NKEYS'(1) << chosen;
  assign pair_mask   = chosen_mask | (NKEYS'(1) << second);
  assign others      = keys & ~chosen_mask;
  assign oth_idx     = lowest(others);
  assign pair_cand   = !rpt_mode && chosen == KEY_A && $onehot(others)
                       && oth_idx >= PAIR_LO && oth_idx <= PAIR_HI;
  assign key_held    = (state == S_SEND) || (state == S_PAIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      chosen     <= '0;
      second     <= '0;
      timer      <= '0;
      frame_go   <= 1'b0;
      frame_stop <= 1'b0;
      data_code  <= '0;
    end else begin
      frame_go   <= 1'b0;
      frame_stop <= 1'b0;
      case (state)
        S_IDLE:
          if (any_key) begin
            chosen <= lowest(keys);
            timer  <= '0;
            state  <= lone_key ? S_ARM : S_BLOCK;
          end
        S_ARM:
          if (!any_key) state <= S_IDLE;
          else if (keys != chosen_mask) state <= S_BLOCK;
          else if (tick_ms) begin
            timer <= timer + 1'b1;
            if (timer == T_ARM) begin
              frame_go  <= 1'b1;
              data_code <= make_code(chosen, 1'b0, sel_strap);
              state     <= S_SEND;
            end
          end
        S_SEND: begin
          if (tick_ms && timer < T_PAIR) timer <= timer + 1'b1;
          if (!keys[chosen]) state <= any_key ? S_BLOCK : S_IDLE;
          else if (pair_cand) begin
            if (timer >= T_PAIR) begin
              second    <= oth_idx;
              frame_go  <= 1'b1;
              data_code <= make_code(oth_idx, 1'b1, sel_strap);
              state     <= S_PAIR;
            end else begin
              frame_stop <= 1'b1;
              state      <= S_BLOCK;
            end
          end
        end
        S_PAIR:
          if (keys != pair_mask) state <= any_key ? S_BLOCK : S_IDLE;
        default:
          if (!any_key) state <= S_IDLE;
      endcase
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> !frame_go); // R2
  AST_GO_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_go && frame_stop)); // R9
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_key |=> !key_held); // R6
  AST_COMBO_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && data_code[5]) |-> !data_code[6]); // R8
  AST_RPT_NO_COMBO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && $past(rpt_mode)) |-> !data_code[5]); // R10
  AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BLOCK && any_key) |=> !frame_go); // R11
endmodule

// File: tb/test_keypad_arbiter.sv
module test_keypad_arbiter;
  localparam int CLK_NS = 10;
  localparam int NK = 64;

  logic clk = 0, rst_n = 0, tick_ms = 0, sel_strap = 1, rpt_mode = 0;
  logic [NK-1:0] keys = '0;
  logic frame_go, frame_stop, key_held;
  logic [7:0] data_code;

  keypad_arbiter i_keypad_arbiter (.clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .keys(keys), .sel_strap(sel_strap), .rpt_mode(rpt_mode), .frame_go(frame_go),
    .frame_stop(frame_stop), .key_held(key_held), .data_code(data_code));

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0, ms_now = 0, t0 = 0, ngo = 0, nstop = 0, gms = 0;
  int errors = 0, checks = 0;
  logic [7:0] gcode = 0;

  always @(negedge clk) begin
    cyc     <= cyc + 1;
    tick_ms <= (cyc[1:0] == 2'd3);
  end
  always @(posedge clk) if (tick_ms) ms_now <= ms_now + 1;
  always @(negedge clk) begin
    if (frame_go) begin ngo++; gcode = data_code; gms = ms_now - t0; end
    if (frame_stop) nstop++;
  end

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int exp_code(int k, logic strap, logic combo);
    return ((strap ? 0 : 1) << 7) | ((!combo && k < 32) ? 64 : 0)
           | (combo ? 32 : 0) | (k % 32);
  endfunction

  task automatic slot();
    @(negedge clk);
    while (cyc[1:0] != 2'd1) @(negedge clk);
  endtask
  task automatic start(logic [NK-1:0] m);
    slot(); keys = m; t0 = ms_now; ngo = 0; nstop = 0;
  endtask
  task automatic at_ms(int n);
    @(negedge clk);
    while (!((ms_now - t0) >= n && cyc[1:0] == 2'd1)) @(negedge clk);
  endtask
  task automatic release_all();
    slot(); keys = '0;
    repeat (3) @(negedge clk);
  endtask
  function automatic logic [NK-1:0] bit_of(int k);
    return NK'(1) << k;
  endfunction

  task automatic combo_case(int off, int k2, string tag, int e_go, int e_stop, int e_held);
    start(bit_of(20));
    at_ms(off); keys = keys | bit_of(k2);
    at_ms(off + 4);
    check({tag, " go count"}, ngo, e_go);
    check({tag, " stop count"}, nstop, e_stop);
    check({tag, " held"}, int'(key_held), e_held);
    if (e_go == 2) check({tag, " combo code"}, int'(gcode), exp_code(k2, sel_strap, 1'b1));
    release_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 go", int'(frame_go), 0);
    check("R1 held", int'(key_held), 0);
    check("R1 code", int'(data_code), 0);
    rst_n = 1;

    start(bit_of(3)); at_ms(60);
    check("R2 one start", ngo, 1);
    check("R2 start tick", gms, 36);
    check("R3 code k3", int'(gcode), exp_code(3, 1'b1, 1'b0));
    check("R6 held while down", int'(key_held), 1);
    slot(); keys = '0; @(negedge clk); @(negedge clk);
    check("R6 held after release", int'(key_held), 0);
    release_all();

    void'($urandom(7));
    for (int i = 0; i < 8; i++) begin
      int k = $urandom % NK;
      sel_strap = 1'($urandom);
      start(bit_of(k)); at_ms(45);
      check("R2 random start", ngo, 1);
      check("R2 random tick", gms, 36);
      check("R3 random code", int'(gcode), exp_code(k, sel_strap, 1'b0));
      release_all();
    end
    sel_strap = 1;

    for (int i = 0; i < 4; i++) begin
      int a = $urandom % NK;
      int b = (a + 1 + ($urandom % (NK - 1))) % NK;
      start(bit_of(a) | bit_of(b)); at_ms(60);
      check("R4 simultaneous", ngo, 0);
      slot(); keys = bit_of(a); at_ms(120);
      check("R11 remaining key blocked", ngo, 0);
      release_all();
    end
    start(bit_of(9)); at_ms(50);
    check("R11 recovery after release", ngo, 1);
    release_all();

    start(bit_of(10)); at_ms(10); keys = keys | bit_of(40); at_ms(60);
    check("R4 second key in window", ngo, 0);
    release_all();

    start(bit_of(7)); at_ms(20); keys = '0; at_ms(60);
    check("R5 short press", ngo, 0);
    release_all();

    start(bit_of(5)); at_ms(50); keys = keys | bit_of(9); at_ms(150);
    check("R7 no new start", ngo, 1);
    check("R7 no stop", nstop, 0);
    check("R7 held", int'(key_held), 1);
    check("R7 code kept", int'(data_code), exp_code(5, 1'b1, 1'b0));
    keys = bit_of(9); @(negedge clk); @(negedge clk);
    check("R6 chosen released", int'(key_held), 0);
    at_ms(200);
    check("R11 leftover key", ngo, 1);
    release_all();

    combo_case(130, 22, "R8 late combo", 2, 0, 1);
    combo_case(126, 21, "R8 boundary combo", 2, 0, 1);
    sel_strap = 0;
    combo_case(140, 23, "R8 strap low combo", 2, 0, 1);
    sel_strap = 1;
    combo_case(80, 21, "R9 early combo", 1, 1, 0);
    combo_case(125, 23, "R9 boundary early", 1, 1, 0);
    combo_case(20, 22, "R4 combo in window", 0, 0, 0);
    combo_case(130, 24, "R7 non-pair key", 1, 0, 1);
    rpt_mode = 1;
    combo_case(130, 22, "R10 repeat mode", 1, 0, 1);
    check("R10 bit5 clear", int'(gcode[5]), 0);
    rpt_mode = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule